// File: doc/BRIEF.md
# Receive Self-Test Pattern Checker

This block checks the receive side of a serial link during built-in self-test. It produces its own copy of a 511-symbol pseudo-random sequence and compares every accepted symbol against it. While it has not yet found the start of the sequence, it hunts. Once a start symbol arrives, it locks and follows the sequence, and it counts mismatches over a sliding window of the most recent symbols. If that window holds too many errors, it drops back to hunting.

The block drives one status pin that is shared with a receive-buffer flag. When self-test is off, the pin carries the buffer flag unchanged. When self-test is on, the checker takes the pin over. The pin is asserted while hunting and deasserted while locked. While locked, it gives a single-cycle asserted pulse when each 511-symbol loop completes. A polarity select input decides whether "asserted" means a high or a low level on the pin, for both uses.

Top module: `rxbist_checker`

## Requirements
- R1: The expected sequence starts at s0 = 9'h1FF and steps as s(k+1) = {s(k)[7:0], s(k)[8] ^ s(k)[4]}, which repeats every 511 symbols. Position 0 is s0 and position 510 is the last symbol of a loop.
- R2: While `bistEn` is 1 and the checker is hunting, the status is asserted. Accepted symbols other than 9'h1FF leave it hunting.
- R3: While hunting, an accepted symbol equal to 9'h1FF locks the checker. The status is deasserted from the next cycle, and the next symbol is compared against s1.
- R4: While locked, the status is deasserted except for exactly one cycle. That cycle directly follows the acceptance of the position-510 symbol.
- R5: While locked, if an accepted symbol brings the count of mismatches among the last 28 accepted symbols to 14, the checker returns to hunting. The status is asserted from the next cycle.
- R6: While any 28 consecutive accepted symbols hold at most 13 mismatches, the checker stays locked.
- R7: Returning to hunting clears the mismatch window and the loop position. After relocking, earlier errors do not count, and the next pulse follows the symbol 510 positions after the new start.
- R8: A cycle with `symValid` at 0 neither compares nor advances the sequence, the position or the window, and it does not cause locking.
- R9: While `bistEn` is 0, the logical status equals `fifoFlag` and the checker is held in hunting (this is also the state after reset). While `bistEn` is 1, `fifoFlag` has no effect.
- R10: With `polHigh` at 1, `statusOut` equals the logical status. With `polHigh` at 0, it is the inverse. This applies in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive symbol clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bistEn | input | 1 | 1 selects self-test use of the status pin |
| polHigh | input | 1 | 1 means the pin is active high, 0 means active low |
| fifoFlag | input | 1 | Buffer flag shown on the pin when self-test is off (active high) |
| symValid | input | 1 | Qualifies `symIn` for this cycle |
| symIn | input | 9 | Received decoded symbol |
| statusOut | output | 1 | Shared status pin, polarity applied |

## Verification
The assertions assume that `bistEn`, `polHigh` and `fifoFlag` change only away from the active clock edge. They also assume that `symIn` is only meaningful when `symValid` is 1. They rely on the loop position and the mismatch count changing only through the control strobes. The stimulus drives every input on the falling edge and holds it steady for the full cycle. It sets `symValid` to 0 during idle gaps, so that idle symbol values are never compared.

// File: rtl/rxbist_pkg.sv
`timescale 1ns/1ps
package rxbist_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } rxbist_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // start symbol seen: align the reference
    logic advance;  // locked symbol accepted: step and record mismatch
    logic clear;    // back to hunting: wipe window and position
  } rxbist_strb_t;

endpackage

// File: rtl/rxbist_datapath.sv
`timescale 1ns/1ps
module rxbist_datapath
  import rxbist_pkg::*;
#(
  parameter int SYM_W = 9,
  parameter int TAP_HI = 8,
  parameter int TAP_LO = 4,
  parameter logic [SYM_W-1:0] START_SYM = '1,
  parameter int WIN_LEN = 28,
  parameter int ERR_LIMIT = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SYM_W-1:0] symIn,
  input  rxbist_strb_t     strb,
  output logic             startMatch,
  output logic             atLast,
  output logic             windowTrip
);

  localparam int LOOP_LEN = (1 << SYM_W) - 1;
  localparam int POS_W = SYM_W;
  localparam int CNT_W = $clog2(WIN_LEN + 1);

  function automatic logic [SYM_W-1:0] stepSym(input logic [SYM_W-1:0] s);
    return {s[SYM_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
  endfunction

  logic [SYM_W-1:0] expSym;
  logic [POS_W-1:0] pos;
  logic [WIN_LEN-1:0] errWin;
  logic [CNT_W-1:0] errCnt;
  logic mismatch;
  logic [CNT_W:0] newCnt;

  assign startMatch = (symIn == START_SYM);
  assign atLast = (pos == POS_W'(LOOP_LEN - 1));
  assign mismatch = (symIn != expSym);
  assign newCnt = {1'b0, errCnt} + (CNT_W+1)'(mismatch) - (CNT_W+1)'(errWin[WIN_LEN-1]);
  assign windowTrip = (newCnt >= (CNT_W+1)'(ERR_LIMIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expSym <= START_SYM;
      pos <= '0;
      errWin <= '0;
      errCnt <= '0;
    end else if (strb.clear) begin
      expSym <= START_SYM;
      pos <= '0;
      errWin <= '0;
      errCnt <= '0;
    end else if (strb.load) begin
      expSym <= stepSym(START_SYM);
      pos <= POS_W'(1);
      errWin <= '0;
      errCnt <= '0;
    end else if (strb.advance) begin
      expSym <= stepSym(expSym);
      pos <= atLast ? '0 : pos + 1'b1;
      errWin <= {errWin[WIN_LEN-2:0], mismatch};
      errCnt <= newCnt[CNT_W-1:0];
    end
  end

  // R1
  ref_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    expSym != '0);

  // R1
  wrap_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.clear && !strb.load && atLast) |=> (expSym == START_SYM));

  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pos < POS_W'(LOOP_LEN));

  // R5
  win_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(errWin) == int'(errCnt));

endmodule

// File: rtl/rxbist_ctrl.sv
`timescale 1ns/1ps
module rxbist_ctrl
  import rxbist_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         bistEn,
  input  logic         symValid,
  input  logic         startMatch,
  input  logic         atLast,
  input  logic         windowTrip,
  output rxbist_strb_t strb,
  output logic         huntActive,
  output logic         endPulse
);

  rxbist_state_e state, stateNxt;
  logic pulseNxt;

  always_comb begin
    strb = '0;
    stateNxt = state;
    pulseNxt = 1'b0;
    if (!bistEn) begin
      strb.clear = 1'b1;
      stateNxt = ST_HUNT;
    end else if (symValid) begin
      unique case (state)
        ST_HUNT: begin
          if (startMatch) begin
            strb.load = 1'b1;
            stateNxt = ST_LOCK;
          end
        end
        ST_LOCK: begin
          if (windowTrip) begin
            strb.clear = 1'b1;
            stateNxt = ST_HUNT;
          end else begin
            strb.advance = 1'b1;
            pulseNxt = atLast;
          end
        end
        default: stateNxt = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_HUNT;
      endPulse <= 1'b0;
    end else begin
      state <= stateNxt;
      endPulse <= pulseNxt;
    end
  end

  assign huntActive = (state == ST_HUNT);

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    endPulse |=> !endPulse);

  // R4
  pulse_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    endPulse |-> (state == ST_LOCK));

  // R5
  trip_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK && bistEn && symValid && windowTrip) |=> (state == ST_HUNT));

  // R9
  disabled_hunt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bistEn |=> (state == ST_HUNT));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bistEn && !symValid) |-> (strb == '0));

endmodule

// File: rtl/rxbist_checker.sv
`timescale 1ns/1ps
module rxbist_checker
  import rxbist_pkg::*;
#(
  parameter int SYM_W = 9,
  parameter int TAP_HI = 8,
  parameter int TAP_LO = 4,
  parameter logic [SYM_W-1:0] START_SYM = '1,
  parameter int WIN_LEN = 28,
  parameter int ERR_LIMIT = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bistEn,
  input  logic             polHigh,
  input  logic             fifoFlag,
  input  logic             symValid,
  input  logic [SYM_W-1:0] symIn,
  output logic             statusOut
);

  rxbist_strb_t strb;
  logic startMatch, atLast, windowTrip;
  logic huntActive, endPulse;
  logic statusLogic;

  rxbist_datapath #(
    .SYM_W(SYM_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO),
    .START_SYM(START_SYM), .WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .symIn(symIn), .strb(strb),
    .startMatch(startMatch), .atLast(atLast), .windowTrip(windowTrip)
  );

  rxbist_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bistEn(bistEn), .symValid(symValid),
    .startMatch(startMatch), .atLast(atLast), .windowTrip(windowTrip),
    .strb(strb), .huntActive(huntActive), .endPulse(endPulse)
  );

  // self-test owns the pin whenever enabled
  assign statusLogic = bistEn ? (huntActive | endPulse) : fifoFlag;
  assign statusOut = polHigh ? statusLogic : ~statusLogic;

  // R2
  hunt_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bistEn && huntActive) |-> (statusOut == polHigh));

  // R3
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bistEn && huntActive && symValid && startMatch) |=> (!huntActive || !bistEn));

endmodule

// File: tb/rxbist_checker_tb.sv
`timescale 1ns/1ps
module rxbist_checker_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bistEn = 1'b0;
  logic polHigh = 1'b1;
  logic fifoFlag = 1'b0;
  logic symValid = 1'b0;
  logic [8:0] symIn = '0;
  logic statusOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [8:0] refSym;
  int refPos;
  int pulseCount;

  always #5 clk = ~clk;

  rxbist_checker u_dut (
    .clk(clk), .rstN(rstN), .bistEn(bistEn), .polHigh(polHigh),
    .fifoFlag(fifoFlag), .symValid(symValid), .symIn(symIn),
    .statusOut(statusOut)
  );

  function automatic logic [8:0] nxt(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  task automatic check(input logic expLogic, input string req, input string what);
    logic expPin;
    expPin = polHigh ? expLogic : ~expLogic;
    nChecks++;
    if (statusOut !== expPin) begin
      nFails++;
      $display("FAIL %s %s: statusOut=%b expected=%b", req, what, statusOut, expPin);
    end
  endtask

  task automatic sendSym(input logic v, input logic [8:0] s);
    @(negedge clk);
    symValid = v;
    symIn = s;
    @(posedge clk);
    #1;
  endtask

  task automatic sendGood();
    int sentPos;
    sentPos = refPos;
    sendSym(1'b1, refSym);
    refSym = nxt(refSym);
    refPos = (refPos == 510) ? 0 : refPos + 1;
    if (sentPos == 510) pulseCount++;
    check(sentPos == 510, "R1 R4", "locked good symbol");
  endtask

  task automatic sendBad(input logic expLogic, input string req);
    int sentPos;
    sentPos = refPos;
    sendSym(1'b1, refSym ^ 9'h001);
    refSym = nxt(refSym);
    refPos = (refPos == 510) ? 0 : refPos + 1;
    check(expLogic | (sentPos == 510), req, "locked bad symbol");
  endtask

  task automatic lockUp();
    sendSym(1'b1, 9'h1FF);
    refSym = nxt(9'h1FF);
    refPos = 1;
    check(1'b0, "R3", "lock on start symbol");
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    bistEn = 1'b0;
    polHigh = 1'b1;
    fifoFlag = 1'b0;
    #12;
    check(1'b0, "R9", "reset, flag follows fifoFlag=0");
    fifoFlag = 1'b1;
    #1;
    check(1'b1, "R9", "flag follows fifoFlag=1");
    polHigh = 1'b0;
    #1;
    check(1'b1, "R10", "active-low pin with fifoFlag=1");
    polHigh = 1'b1;
    fifoFlag = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_hunt();
    @(negedge clk);
    bistEn = 1'b1;
    fifoFlag = 1'b0;
    #1;
    check(1'b1, "R2 R9", "enabled hunting overrides fifoFlag");
    sendSym(1'b1, 9'h0AA);
    check(1'b1, "R2", "non-start symbol keeps hunting");
    sendSym(1'b1, 9'h1FE);
    check(1'b1, "R2", "near-start symbol keeps hunting");
    sendSym(1'b0, 9'h1FF);
    check(1'b1, "R8", "invalid start symbol ignored");
  endtask

  task automatic t_loops();
    pulseCount = 0;
    lockUp();
    for (int i = 0; i < 1100; i++) begin
      if (i % 97 == 5) begin
        sendSym(1'b0, refSym ^ 9'h055);
        check(1'b0, "R8", "idle cycle while locked");
      end
      sendGood();
    end
    nChecks++;
    if (pulseCount != 2) begin
      nFails++;
      $display("FAIL R4 pulse count: actual=%0d expected=2", pulseCount);
    end
  endtask

  task automatic t_window();
    for (int i = 0; i < 13; i++) sendBad(1'b0, "R6");
    for (int i = 0; i < 15; i++) sendGood();
    for (int i = 0; i < 13; i++) sendBad(1'b0, "R6");
    sendBad(1'b1, "R5");
    for (int i = 0; i < 4; i++) begin
      sendSym(1'b1, refSym);
      refSym = nxt(refSym);
      check(1'b1, "R5 R2", "stays hunting after loss");
    end
  endtask

  task automatic t_relock();
    int gap;
    lockUp();
    for (int i = 0; i < 13; i++) sendBad(1'b0, "R7");
    gap = 13;
    while (refPos != 510) begin
      sendGood();
      gap++;
    end
    sendGood();
    gap++;
    nChecks++;
    if (gap != 510) begin
      nFails++;
      $display("FAIL R7 symbols to pulse after relock: actual=%0d expected=510", gap);
    end
    sendGood();
  endtask

  task automatic t_polarity();
    @(negedge clk);
    polHigh = 1'b0;
    #1;
    check(1'b0, "R10", "locked, active-low pin");
    sendGood();
    @(negedge clk);
    bistEn = 1'b0;
    fifoFlag = 1'b1;
    #1;
    check(1'b1, "R9 R10", "disabled, fifoFlag active-low");
    @(negedge clk);
    bistEn = 1'b1;
    fifoFlag = 1'b0;
    #1;
    check(1'b1, "R9 R10", "re-enabled hunting, active-low");
    sendSym(1'b1, 9'h1FF);
    check(1'b0, "R3 R10", "lock with active-low pin");
    polHigh = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_hunt();
    t_loops();
    t_window();
    t_relock();
    t_polarity();
    finish_run();
  end

endmodule